// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one channel of a direct memory access engine. Once started, it copies a programmed number of items from a source pointer to a destination pointer through a pair of simple bus master ports, one for reads and one for writes. Each item is 1, 2 or 4 bytes wide. Each pointer can step after every item, or stay fixed so that it can address a peripheral data register. One of the two pointers can be confined to an aligned power-of-two window, so that it wraps inside that window.

Register decoding sits outside the channel. A control unit writes the two pointers and the reload length through strobed inputs, and holds the mode fields steady on dedicated inputs. A selectable request line can pace the items one at a time. Before an item is written, its bytes can be reversed. The channel reports that it is busy, shows the items left in the running sequence, keeps a sticky error flag for each bus port, and pulses a completion flag at the end of a sequence.

Top module: `dmach_engine`

## Requirements
- R1: `xfer_size` 0 moves bytes, 1 moves halfwords and 2 (or 3) moves words. Each enabled pointer steps by 1, 2 or 4 after its bus phase completes without error.
- R2: `rd_inc_en` and `wr_inc_en` enable pointer stepping separately. A pointer whose enable is low presents the same address for every item.
- R3: When `ring_bits` = n is nonzero, only bits n-1..0 of the selected pointer change when it steps, so that pointer wraps inside its aligned 2^n-byte window. `ring_on_wr` = 0 selects the read pointer and 1 selects the write pointer. The other pointer steps freely. n = 0 turns wrapping off.
- R4: `remaining` shows the items left in the running sequence and drops by one after each successful write. A `set_count` strobe changes only the reload length, which a later `trigger` copies into `remaining`.
- R5: Write data is right-justified, and the bytes above the item size are zero. With `swap_en` = 1, a halfword is written as {d[7:0], d[15:8]} and a word as {d[7:0], d[15:8], d[23:16], d[31:24]}. Byte items are unchanged.
- R6: `busy` rises in the cycle after a `trigger` accepted while idle, and falls in the same cycle that `done` pulses high for exactly one cycle after the last write completes. A trigger with a zero reload length pulses `done` without raising `busy`.
- R7: A read completes before its write is issued, and `rd_req` and `wr_req` are never high together. A request stays high with a stable address and data until it is acknowledged.
- R8: With `pace_en` = 1, each item waits until `dreq[pace_sel]` is high before its read is issued. With `pace_en` = 0, items run back to back.
- R9: A read acknowledged with `rd_fault` sets `rd_err_flag`. A write acknowledged with `wr_fault` sets `wr_err_flag`, and that write does not decrement `remaining`. Either fault stops the channel and drops `busy` in the next cycle. `any_err` is the OR of the two flags.
- R10: Each error flag stays set until a pulse on its own clear input (`clr_rd_err`, `clr_wr_err`) clears it. If a fault and a clear arrive in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigger | input | 1 | Start a sequence (ignored while busy) |
| set_rd_addr | input | 1 | Load `cfg_data` into the read pointer |
| set_wr_addr | input | 1 | Load `cfg_data` into the write pointer |
| set_count | input | 1 | Load `cfg_data[CW-1:0]` as the reload length |
| cfg_data | input | AW | Configuration write data |
| clr_rd_err | input | 1 | Clear the read error flag |
| clr_wr_err | input | 1 | Clear the write error flag |
| xfer_size | input | 2 | Item size code |
| rd_inc_en | input | 1 | Step the read pointer |
| wr_inc_en | input | 1 | Step the write pointer |
| ring_bits | input | RW | Wrap window exponent, 0 = off |
| ring_on_wr | input | 1 | 0: wrap the read pointer, 1: wrap the write pointer |
| swap_en | input | 1 | Reverse the bytes within an item |
| pace_en | input | 1 | Enable request pacing |
| pace_sel | input | SW | Request line index |
| dreq | input | NREQ | Data request lines |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address (current read pointer) |
| rd_size | output | 2 | Read size code |
| rd_ack | input | 1 | Read acknowledge |
| rd_data | input | 32 | Read data, right-justified |
| rd_fault | input | 1 | Read error with the acknowledge |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address (current write pointer) |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data, right-justified |
| wr_ack | input | 1 | Write acknowledge |
| wr_fault | input | 1 | Write error with the acknowledge |
| busy | output | 1 | Sequence in progress |
| remaining | output | CW | Items left in the running sequence |
| rd_err_flag | output | 1 | Sticky read error |
| wr_err_flag | output | 1 | Sticky write error |
| any_err | output | 1 | OR of both error flags |
| done | output | 1 | One-cycle completion pulse |

## Verification
All state is registered. `busy` and `remaining` therefore change one cycle after an accepted trigger. `rd_req` rises one cycle after the pacing condition holds, and `wr_req` rises one cycle after the read acknowledge. The step in `remaining`, the error flags and `done` all appear in the cycle after the acknowledge that causes them. The bench drives inputs and returns acknowledges on the falling edge. It samples outputs on a later falling edge, so each check lands half a cycle after the register edge that should have updated the value. It logs every acknowledged write, with address and data, at the falling edge where the acknowledge is given. Each log entry is compared with an address and data sequence that the bench computes from the size, step, wrap and swap rules.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PACE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dmach_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/dmach_ptr_step.sv
module dmach_ptr_step #(
    parameter int AW = 32,
    parameter int RW = 5
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    size,
    input  logic          inc_en,
    input  logic [RW-1:0] ring_n,
    input  logic          ring_act,
    output logic [AW-1:0] nxt
);
    import dmach_pkg::*;

    logic [AW-1:0] step;
    logic [AW-1:0] live_mask;
    logic [AW-1:0] sum;

    always_comb begin
        case (size)
            SZ_BYTE: step = AW'(1);
            SZ_HALF: step = AW'(2);
            default: step = AW'(4);
        endcase
        if (ring_act && (ring_n != '0)) begin
            live_mask = ~({AW{1'b1}} << ring_n);
        end else begin
            live_mask = {AW{1'b1}};
        end
        sum = cur + step;
        if (inc_en) begin
            nxt = (cur & ~live_mask) | (sum & live_mask);
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/dmach_lane_fmt.sv
module dmach_lane_fmt #(
    parameter int NB = 4
) (
    input  logic [8*NB-1:0] raw,
    input  logic [1:0]      size,
    input  logic            swap,
    output logic [8*NB-1:0] fmt
);
    import dmach_pkg::*;

    localparam int DW = 8 * NB;

    logic [DW-1:0] kept;
    logic [2:0]    nbytes;

    always_comb begin
        case (size)
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    for (genvar b = 0; b < NB; b++) begin : g_keep
        assign kept[8*b +: 8] = (b < int'(nbytes)) ? raw[8*b +: 8] : 8'h00;
    end

    always_comb begin
        fmt = kept;
        if (swap) begin
            case (size)
                SZ_BYTE: fmt = kept;
                SZ_HALF: fmt = {{(DW-16){1'b0}}, kept[7:0], kept[15:8]};
                default: fmt = {{(DW-32){1'b0}}, kept[7:0], kept[15:8],
                                kept[23:16], kept[31:24]};
            endcase
        end
    end

endmodule

// File: rtl/dmach_engine.sv
module dmach_engine #(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int RW   = 5,
    parameter int NREQ = 4,
    localparam int SW  = $clog2(NREQ),
    localparam int DW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trigger,
    input  logic            set_rd_addr,
    input  logic            set_wr_addr,
    input  logic            set_count,
    input  logic [AW-1:0]   cfg_data,
    input  logic            clr_rd_err,
    input  logic            clr_wr_err,
    input  logic [1:0]      xfer_size,
    input  logic            rd_inc_en,
    input  logic            wr_inc_en,
    input  logic [RW-1:0]   ring_bits,
    input  logic            ring_on_wr,
    input  logic            swap_en,
    input  logic            pace_en,
    input  logic [SW-1:0]   pace_sel,
    input  logic [NREQ-1:0] dreq,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    output logic [1:0]      rd_size,
    input  logic            rd_ack,
    input  logic [DW-1:0]   rd_data,
    input  logic            rd_fault,
    output logic            wr_req,
    output logic [AW-1:0]   wr_addr,
    output logic [1:0]      wr_size,
    output logic [DW-1:0]   wr_data,
    input  logic            wr_ack,
    input  logic            wr_fault,
    output logic            busy,
    output logic [CW-1:0]   remaining,
    output logic            rd_err_flag,
    output logic            wr_err_flag,
    output logic            any_err,
    output logic            done
);
    import dmach_pkg::*;

    typedef struct packed {
        dmach_state_e  st;
        logic [AW-1:0] rp;
        logic [AW-1:0] wp;
        logic [CW-1:0] rem;
        logic [CW-1:0] reload;
        logic [DW-1:0] hold;
        logic          rerr;
        logic          werr;
        logic          fin;
    } chan_regs_t;

    chan_regs_t r_q, r_d;

    logic [AW-1:0] ptr_cur [2];
    logic [AW-1:0] ptr_nxt [2];
    logic          ptr_inc [2];
    logic          ptr_ring[2];
    logic [DW-1:0] fmt_data;
    logic          pace_ok;

    assign ptr_cur[0]  = r_q.rp;
    assign ptr_cur[1]  = r_q.wp;
    assign ptr_inc[0]  = rd_inc_en;
    assign ptr_inc[1]  = wr_inc_en;
    assign ptr_ring[0] = ~ring_on_wr;
    assign ptr_ring[1] = ring_on_wr;

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        dmach_ptr_step #(.AW(AW), .RW(RW)) u_step (
            .cur     (ptr_cur[g]),
            .size    (xfer_size),
            .inc_en  (ptr_inc[g]),
            .ring_n  (ring_bits),
            .ring_act(ptr_ring[g]),
            .nxt     (ptr_nxt[g])
        );
    end

    dmach_lane_fmt #(.NB(DW/8)) u_fmt (
        .raw (rd_data),
        .size(xfer_size),
        .swap(swap_en),
        .fmt (fmt_data)
    );

    assign pace_ok = ~pace_en | dreq[pace_sel];

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        if (set_rd_addr) r_d.rp = cfg_data;
        if (set_wr_addr) r_d.wp = cfg_data;
        if (set_count)   r_d.reload = cfg_data[CW-1:0];
        if (clr_rd_err)  r_d.rerr = 1'b0;
        if (clr_wr_err)  r_d.werr = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (trigger) begin
                    r_d.rem = r_q.reload;
                    if (r_q.reload == '0) begin
                        r_d.fin = 1'b1;
                    end else begin
                        r_d.st = ST_PACE;
                    end
                end
            end
            ST_PACE: begin
                if (pace_ok) r_d.st = ST_READ;
            end
            ST_READ: begin
                if (rd_ack) begin
                    if (rd_fault) begin
                        r_d.rerr = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.hold = fmt_data;
                        r_d.rp   = ptr_nxt[0];
                        r_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    if (wr_fault) begin
                        r_d.werr = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.wp  = ptr_nxt[1];
                        r_d.rem = r_q.rem - 1'b1;
                        if (r_q.rem == CW'(1)) begin
                            r_d.st  = ST_IDLE;
                            r_d.fin = 1'b1;
                        end else begin
                            r_d.st = ST_PACE;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req      = (r_q.st == ST_READ);
    assign wr_req      = (r_q.st == ST_WRITE);
    assign rd_addr     = r_q.rp;
    assign wr_addr     = r_q.wp;
    assign rd_size     = xfer_size;
    assign wr_size     = xfer_size;
    assign wr_data     = r_q.hold;
    assign busy        = (r_q.st != ST_IDLE);
    assign remaining   = r_q.rem;
    assign rd_err_flag = r_q.rerr;
    assign wr_err_flag = r_q.werr;
    assign any_err     = r_q.rerr | r_q.werr;
    assign done        = r_q.fin;

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !set_rd_addr) |=> (rd_req && $stable(rd_addr))); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !set_wr_addr) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_RD_FAULT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_fault) |=> (!busy && rd_err_flag && !wr_req)); // R9
    AST_WR_FAULT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && wr_fault) |=> (!busy && wr_err_flag && $stable(remaining))); // R9
    AST_PACE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_req && !wr_req && pace_en && !dreq[pace_sel]) |=> !rd_req); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && !wr_fault) |=> (remaining == $past(remaining) - 1'b1)); // R4

endmodule

// File: tb/dmach_engine_tb.sv
module dmach_engine_tb;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int RW = 5;
    localparam int NREQ = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            trigger = 0, set_rd_addr = 0, set_wr_addr = 0, set_count = 0;
    logic [AW-1:0]   cfg_data = '0;
    logic            clr_rd_err = 0, clr_wr_err = 0;
    logic [1:0]      xfer_size = 2'd2;
    logic            rd_inc_en = 1, wr_inc_en = 1;
    logic [RW-1:0]   ring_bits = '0;
    logic            ring_on_wr = 0, swap_en = 0, pace_en = 0;
    logic [1:0]      pace_sel = '0;
    logic [NREQ-1:0] dreq = '0;
    logic            rd_req, wr_req, busy, rd_err_flag, wr_err_flag, any_err, done;
    logic [AW-1:0]   rd_addr, wr_addr;
    logic [1:0]      rd_size, wr_size;
    logic            rd_ack = 0, rd_fault = 0, wr_ack = 0, wr_fault = 0;
    logic [31:0]     rd_data = '0, wr_data;
    logic [CW-1:0]   remaining;

    dmach_engine #(.AW(AW), .CW(CW), .RW(RW), .NREQ(NREQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .set_rd_addr(set_rd_addr),
        .set_wr_addr(set_wr_addr), .set_count(set_count), .cfg_data(cfg_data),
        .clr_rd_err(clr_rd_err), .clr_wr_err(clr_wr_err), .xfer_size(xfer_size),
        .rd_inc_en(rd_inc_en), .wr_inc_en(wr_inc_en), .ring_bits(ring_bits),
        .ring_on_wr(ring_on_wr), .swap_en(swap_en), .pace_en(pace_en),
        .pace_sel(pace_sel), .dreq(dreq), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_ack(rd_ack), .rd_data(rd_data), .rd_fault(rd_fault),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_fault(wr_fault), .busy(busy), .remaining(remaining),
        .rd_err_flag(rd_err_flag), .wr_err_flag(wr_err_flag), .any_err(any_err),
        .done(done)
    );

    int n_chk = 0, n_bad = 0;
    int rd_idx = 0, wr_idx = 0, rd_ok = 0, rd_wait = 0, wr_wait = 0;
    int rd_lat = 0, wr_lat = 1, rd_err_at = -1, wr_err_at = -1;
    int done_cnt = 0, done_wide = 0, overlap = 0, order_bad = 0;
    logic done_prev = 0;
    logic [31:0] log_a [64];
    logic [31:0] log_d [64];

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[7:0] ^ 8'hA1, a[7:0] ^ 8'h5B, a[7:0] + 8'h37, a[7:0] + 8'h02};
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] raw, input logic [1:0] sz, input logic sw);
        logic [31:0] k;
        k = (sz == 2'd0) ? {24'h0, raw[7:0]} : (sz == 2'd1) ? {16'h0, raw[15:0]} : raw;
        if (sw && sz == 2'd1) k = {16'h0, k[7:0], k[15:8]};
        else if (sw && sz >= 2'd2) k = {k[7:0], k[15:8], k[23:16], k[31:24]};
        return k;
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] a, input logic [1:0] sz,
                                              input logic inc, input int rn, input logic wrap);
        logic [31:0] st, win;
        if (!inc) return a;
        st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        if (!wrap || rn == 0) return a + st;
        win = (32'd1 << rn) - 32'd1;
        return (a & ~win) | ((a + st) & win);
    endfunction

    // bus responder and monitors, all on the falling edge
    always @(negedge clk) begin
        if (rd_req && wr_req) overlap++;
        if (done) begin
            done_cnt++;
            if (done_prev) done_wide++;
        end
        done_prev = done;
        if (rd_req && !rd_ack) begin
            if (rd_wait >= rd_lat) begin
                rd_ack = 1; rd_data = memval(rd_addr);
                rd_fault = (rd_idx == rd_err_at);
                if (!rd_fault) rd_ok++;
                rd_idx++; rd_wait = 0;
            end else rd_wait++;
        end else begin
            rd_ack = 0; rd_fault = 0;
        end
        if (wr_req && !wr_ack) begin
            if (wr_wait >= wr_lat) begin
                wr_ack = 1; wr_fault = (wr_idx == wr_err_at);
                if (wr_idx >= rd_ok) order_bad++;
                log_a[wr_idx] = wr_addr; log_d[wr_idx] = wr_data;
                wr_idx++; wr_wait = 0;
            end else wr_wait++;
        end else begin
            wr_ack = 0; wr_fault = 0;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog(input logic [31:0] ra, input logic [31:0] wa, input int n);
        @(negedge clk);
        cfg_data = ra; set_rd_addr = 1;
        @(negedge clk);
        set_rd_addr = 0; cfg_data = wa; set_wr_addr = 1;
        @(negedge clk);
        set_wr_addr = 0; cfg_data = n; set_count = 1;
        @(negedge clk);
        set_count = 0;
        rd_idx = 0; wr_idx = 0; rd_ok = 0;
    endtask

    task automatic fire();
        @(negedge clk);
        trigger = 1;
        @(negedge clk);
        trigger = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic run_seq(input string req, input logic [31:0] ra, input logic [31:0] wa,
                           input int n, input logic [1:0] sz, input logic ir, input logic iw,
                           input int rn, input logic row, input logic sw);
        logic [31:0] ea, eb;
        int d0;
        xfer_size = sz; rd_inc_en = ir; wr_inc_en = iw; ring_bits = RW'(rn);
        ring_on_wr = row; swap_en = sw;
        prog(ra, wa, n);
        d0 = done_cnt;
        fire();
        check(busy === 1'b1, "R6", "busy after trigger", {31'd0, busy}, 32'd1);
        wait_idle();
        cyc(1);
        check(done_cnt == d0 + 1, "R6", "done pulses", done_cnt - d0, 1);
        check(remaining == 0, "R4", "remaining at end", remaining, 0);
        check(wr_idx == n, req, "write count", wr_idx, n);
        ea = ra; eb = wa;
        for (int i = 0; i < n && i < wr_idx; i++) begin
            check(log_a[i] == eb, req, "write address", log_a[i], eb);
            check(log_d[i] == exp_data(memval(ea), sz, sw), req, "write data",
                  log_d[i], exp_data(memval(ea), sz, sw));
            ea = exp_next(ea, sz, ir, rn, !row);
            eb = exp_next(eb, sz, iw, rn, row);
        end
        check(rd_addr == ea, req, "final read pointer", rd_addr, ea);
    endtask

    task automatic t_reset();
        check(!busy && !done && !rd_req && !wr_req, "R6", "idle after reset", {28'd0, busy, done, rd_req, wr_req}, 0);
        check(remaining == 0, "R4", "remaining after reset", remaining, 0);
        check(!rd_err_flag && !wr_err_flag && !any_err, "R9", "flags after reset",
              {29'd0, rd_err_flag, wr_err_flag, any_err}, 0);
    endtask

    task automatic t_sizes();
        run_seq("R1", 32'h1000, 32'h2000, 4, 2'd2, 1, 1, 0, 0, 0);
        run_seq("R1", 32'h1101, 32'h2203, 5, 2'd0, 1, 1, 0, 0, 0);
        run_seq("R5", 32'h1302, 32'h2400, 4, 2'd1, 1, 1, 0, 0, 1);
        run_seq("R5", 32'h1400, 32'h2500, 3, 2'd2, 1, 1, 0, 0, 1);
        run_seq("R5", 32'h1501, 32'h2601, 3, 2'd0, 1, 1, 0, 0, 1);
    endtask

    task automatic t_noinc();
        run_seq("R2", 32'h4000, 32'h5000, 4, 2'd2, 0, 1, 0, 0, 0);
        run_seq("R2", 32'h4100, 32'h5100, 4, 2'd1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_ring();
        run_seq("R3", 32'h0104, 32'h0800, 5, 2'd2, 1, 1, 3, 0, 0);
        run_seq("R3", 32'h0300, 32'h020C, 6, 2'd1, 1, 1, 4, 1, 0);
        run_seq("R3", 32'h03FC, 32'h07FC, 3, 2'd2, 1, 1, 0, 1, 0);
    endtask

    task automatic t_pace_count();
        int d0;
        xfer_size = 2'd2; rd_inc_en = 1; wr_inc_en = 1; ring_bits = '0; swap_en = 0;
        pace_en = 1; pace_sel = 2'd1; dreq = '0;
        prog(32'h6000, 32'h7000, 5);
        d0 = done_cnt;
        fire();
        check(remaining == 5, "R4", "remaining after trigger", remaining, 5);
        cyc(10);
        check(rd_idx == 0 && !rd_req, "R8", "no read without request", rd_idx, 0);
        cfg_data = 3; set_count = 1;
        @(negedge clk);
        set_count = 0;
        check(remaining == 5, "R4", "reload write leaves remaining", remaining, 5);
        dreq[2] = 1;
        cyc(6);
        check(rd_idx == 0, "R8", "unselected request ignored", rd_idx, 0);
        dreq = 4'b0010;
        @(negedge clk);
        dreq = '0;
        cyc(10);
        check(wr_idx == 1, "R8", "one item per request", wr_idx, 1);
        check(remaining == 4, "R4", "remaining after one item", remaining, 4);
        dreq = 4'b0010;
        wait_idle();
        cyc(1);
        check(wr_idx == 5 && done_cnt == d0 + 1, "R8", "paced sequence completes", wr_idx, 5);
        rd_idx = 0; wr_idx = 0; rd_ok = 0;
        fire();
        check(remaining == 3, "R4", "new reload used", remaining, 3);
        wait_idle();
        check(wr_idx == 3, "R4", "second sequence length", wr_idx, 3);
        pace_en = 0; dreq = '0;
    endtask

    task automatic t_done();
        int d0;
        check(done_wide == 0, "R6", "done wider than one cycle", done_wide, 0);
        prog(32'h0, 32'h0, 0);
        d0 = done_cnt;
        @(negedge clk);
        trigger = 1;
        @(negedge clk);
        trigger = 0;
        check(done === 1'b1 && !busy, "R6", "zero reload done without busy", {30'd0, done, busy}, 2);
        cyc(2);
        check(done_cnt == d0 + 1 && rd_idx == 0, "R6", "zero reload no traffic", done_cnt - d0, 1);
        check(overlap == 0 && order_bad == 0, "R7", "read/write ordering", overlap + order_bad, 0);
    endtask

    task automatic t_errors();
        int d0;
        xfer_size = 2'd2; rd_inc_en = 1; wr_inc_en = 1; swap_en = 0;
        prog(32'h8000, 32'h9000, 4);
        rd_err_at = 2; d0 = done_cnt;
        fire();
        wait_idle();
        cyc(1);
        rd_err_at = -1;
        check(rd_err_flag && any_err && !wr_err_flag, "R9", "read fault flags",
              {29'd0, rd_err_flag, wr_err_flag, any_err}, 32'h5);
        check(wr_idx == 2 && remaining == 2, "R9", "read fault stops", wr_idx, 2);
        check(done_cnt == d0, "R9", "no done on fault", done_cnt - d0, 0);
        cyc(3);
        check(rd_err_flag === 1'b1, "R10", "read flag sticky", {31'd0, rd_err_flag}, 1);
        clr_rd_err = 1;
        @(negedge clk);
        clr_rd_err = 0;
        check(!rd_err_flag && !any_err, "R10", "read flag cleared", {31'd0, rd_err_flag}, 0);
        prog(32'h8100, 32'h9100, 3);
        wr_err_at = 0;
        fire();
        wait_idle();
        cyc(1);
        wr_err_at = -1;
        check(wr_err_flag && any_err && !rd_err_flag, "R9", "write fault flags",
              {29'd0, rd_err_flag, wr_err_flag, any_err}, 32'h3);
        check(remaining == 3 && wr_addr == 32'h9100, "R9", "write fault no decrement", remaining, 3);
        clr_wr_err = 1;
        @(negedge clk);
        clr_wr_err = 0;
        check(!wr_err_flag && !any_err, "R10", "write flag cleared", {31'd0, wr_err_flag}, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_sizes();
        t_noinc();
        t_ring();
        rd_lat = 2; wr_lat = 0;
        t_pace_count();
        rd_lat = 0; wr_lat = 1;
        t_errors();
        t_done();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule